// File: doc/BRIEF.md
# Buffered SPI Slave Controller

This block is an SPI slave with one transmit holding byte and one receive holding byte, both reached through a single data register. Software uses a small register bus clocked by the system clock. Serial traffic runs on the external serial clock. The slave clock, slave data input and chip select are resynchronised into the system clock domain, and all shifting happens there. A byte that software writes waits in the transmit holding register. It moves into the shifter when the external master opens the next frame. This lets software queue the next byte while the current frame is still shifting, so frames can run back to back.

Four status flags guide the driver software: transmit-empty, receive-full, busy and overrun. Software can run full duplex, reading every received byte. It can also run transmit-only, leaving received bytes unread. In that case overrun shows up after the second frame, and the byte kept is the first one. Clock polarity and clock phase can be selected. Frames are eight bits and are sent most significant bit first by default.

Top module: `spi_slv_buf`

## Requirements
- R1: While the enable bit (control bit 0) is 0, data-register writes are ignored and serial frames leave every flag unchanged, so status stays at its reset value 0x02.
- R2: A data-register write loads the transmit holding byte and clears transmit-empty (status bit 1). Hardware sets transmit-empty again when that byte enters the shifter, which happens at the start of the next frame.
- R3: A byte written while the previous frame is still shifting goes out in the very next frame, even when chip select stays low between the two frames.
- R4: When a complete frame arrives and the receive holding byte is free, the byte is stored and receive-full (status bit 0) is set. A data-register read returns the byte and clears receive-full.
- R5: After a data-register write to an idle slave, busy (status bit 7) stays 0 for the first system clock edge after the write and becomes 1 after the second.
- R6: Busy stays 1 while a frame is in progress or the transmit holding byte is full. It falls to 0 once the last frame has completed and transmit-empty is 1.
- R7: If a frame completes while receive-full is still set, overrun (status bit 6) is set. The stored byte is kept and the new byte is discarded. In transmit-only use this happens on the second frame.
- R8: Overrun is cleared by a data-register read followed by a status-register read. A status read alone does not clear it.
- R9: If a frame starts while transmit-empty is 1, the slave sends the last transmitted byte again and raises no flag.
- R10: Control bit 1 selects the serial clock idle level and control bit 2 selects sampling on the second edge. Both the (idle high, second edge) and (idle low, first edge) modes transfer bytes most significant bit first.
- R11: The register map is: address 0 = control (read/write), address 1 = status (read), address 2 = data. After reset, control reads 0x00 and status reads 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock. Each serial clock level must last at least four system clocks, so every edge is seen once after resynchronisation. Data in from the master must stay steady across the sampling edge. The bench holds each serial clock level for eight system clocks, and it changes the master's data only on the shifting edge or while chip select is high. It also changes control settings only while chip select is high and no frame is open, because that is the window in which the assertions on busy and the receive flags stay valid.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2
   } reg_sel_e;

   // status bit positions
   localparam int unsigned STAT_RXF  = 0;
   localparam int unsigned STAT_TXE  = 1;
   localparam int unsigned STAT_OVR  = 6;
   localparam int unsigned STAT_BUSY = 7;

   typedef struct packed {
      logic late_edge;   // bit 2: sample on second edge
      logic idle_high;   // bit 1: clock idle level
      logic enable;      // bit 0
   } ctrl_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int unsigned WIDTH = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_slv_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign d_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
   parameter int unsigned DATA_W = 8,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              idle_high,
   input  logic              late_edge,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              csn_s,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_full,
   output logic              take,
   output logic              miso,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic              in_frame
);
   localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic              sck_d, csn_d;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] tx_sr, rx_sr, last_byte, tx_next, rx_next, shifted;
   logic              lead, trail, sample_ev, shift_ev, load_ev, done_now, csn_fall;

   always_comb begin
      lead      = idle_high ? (sck_d & ~sck_s) : (~sck_d & sck_s);
      trail     = idle_high ? (~sck_d & sck_s) : (sck_d & ~sck_s);
      csn_fall  = csn_d & ~csn_s;
      sample_ev = en & ~csn_s & (late_edge ? trail : lead);
      shift_ev  = en & ~csn_s & (late_edge ? lead : trail);
      done_now  = sample_ev & (cnt == LAST);
      load_ev   = late_edge ? (shift_ev & (cnt == '0))
                            : (en & (csn_fall | (done_now & ~csn_s)));
      take      = load_ev & tx_full;
      tx_next   = tx_full ? tx_byte : last_byte;
   end

   if (LSB_FIRST) begin : g_lsb
      assign miso    = tx_sr[0];
      assign shifted = {1'b0, tx_sr[DATA_W-1:1]};
      assign rx_next = {mosi_s, rx_sr[DATA_W-1:1]};
   end else begin : g_msb
      assign miso    = tx_sr[DATA_W-1];
      assign shifted = {tx_sr[DATA_W-2:0], 1'b0};
      assign rx_next = {rx_sr[DATA_W-2:0], mosi_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         csn_d     <= 1'b1;
         cnt       <= '0;
         tx_sr     <= '0;
         rx_sr     <= '0;
         last_byte <= '0;
         rx_byte   <= '0;
         done      <= 1'b0;
         in_frame  <= 1'b0;
      end else begin
         sck_d <= sck_s;
         csn_d <= csn_s;
         done  <= done_now;
         if (load_ev) begin
            tx_sr     <= tx_next;
            last_byte <= tx_next;
         end else if (shift_ev && cnt != '0) begin
            tx_sr <= shifted;
         end
         if (done_now) rx_byte <= rx_next;
         if (!en || csn_s) begin
            cnt      <= '0;
            in_frame <= 1'b0;
         end else begin
            if (sample_ev) begin
               rx_sr <= rx_next;
               cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
            if (done_now)                      in_frame <= ~late_edge & take;
            else if (sample_ev || take)        in_frame <= 1'b1;
            else if (late_edge && load_ev)     in_frame <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_slv_buf.sv
module spi_slv_buf
   import spi_slv_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  spi_sck,
   input  logic                  spi_mosi,
   input  logic                  spi_csn,
   output logic                  spi_miso
);
   if (DATA_W < 8) begin : g_bad_width
      $error("spi_slv_buf: DATA_W must be at least 8 to hold the status layout");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] tx_buf, rx_buf, rx_byte;
   logic              txe, rxf, ovr, ovr_arm, busy, wr_d1, wr_d2;
   logic              ovr_n, arm_n;
   logic              wr_ctrl, wr_data, rd_data, rd_stat, rxf_eff;
   logic              take, done, in_frame;
   logic              sck_s, mosi_s, csn_s;

   spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_async({spi_csn, spi_mosi, spi_sck}),
      .d_sync({csn_s, mosi_s, sck_s})
   );

   spi_slv_shift #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(ctrl.enable),
      .idle_high(ctrl.idle_high), .late_edge(ctrl.late_edge),
      .sck_s(sck_s), .mosi_s(mosi_s), .csn_s(csn_s),
      .tx_byte(tx_buf), .tx_full(~txe), .take(take), .miso(spi_miso),
      .done(done), .rx_byte(rx_byte), .in_frame(in_frame)
   );

   always_comb begin
      wr_ctrl = bus_sel & bus_wr & (bus_addr == REG_CTRL);
      wr_data = bus_sel & bus_wr & (bus_addr == REG_DATA) & ctrl.enable;
      rd_data = bus_sel & ~bus_wr & (bus_addr == REG_DATA);
      rd_stat = bus_sel & ~bus_wr & (bus_addr == REG_STAT);
      rxf_eff = rxf & ~rd_data;
      ovr_n = ovr;
      arm_n = ovr_arm;
      if (rd_stat && ovr_arm) begin
         ovr_n = 1'b0;
         arm_n = 1'b0;
      end
      if (rd_data && ovr) arm_n = 1'b1;
      if (done && rxf_eff) ovr_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         tx_buf  <= '0;
         txe     <= 1'b1;
         rx_buf  <= '0;
         rxf     <= 1'b0;
         ovr     <= 1'b0;
         ovr_arm <= 1'b0;
         busy    <= 1'b0;
         wr_d1   <= 1'b0;
         wr_d2   <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[2:0]);
         if (!ctrl.enable) txe <= 1'b1;
         else if (wr_data) begin
            tx_buf <= bus_wdata;
            txe    <= 1'b0;
         end else if (take) txe <= 1'b1;
         wr_d1 <= wr_data;
         wr_d2 <= wr_d1;
         busy  <= ctrl.enable & (wr_d2 | in_frame | (busy & ~txe));
         if (done && !rxf_eff) begin
            rx_buf <= rx_byte;
            rxf    <= 1'b1;
         end else if (rd_data) rxf <= 1'b0;
         ovr     <= ovr_n;
         ovr_arm <= arm_n;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_CTRL: bus_rdata[2:0] = ctrl;
         REG_STAT: begin
            bus_rdata[STAT_RXF]  = rxf;
            bus_rdata[STAT_TXE]  = txe;
            bus_rdata[STAT_OVR]  = ovr;
            bus_rdata[STAT_BUSY] = busy;
         end
         REG_DATA: bus_rdata = rx_buf;
         default: bus_rdata = '0;
      endcase
   end

   AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.enable && !$past(ctrl.enable) && !rxf) |=> !rxf); // R1
   AST_TXE_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !txe); // R2
   AST_RXF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rxf); // R4
   AST_BUSY_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !busy && !in_frame && !wr_d1 && !wr_d2) |=> !busy); // R5
   AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.enable && in_frame) |=> busy); // R6
   AST_OVR_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rxf && !rd_data) |=> (ovr && $stable(rx_buf))); // R7
endmodule

// File: tb/spi_slv_buf_tb.sv
module spi_slv_buf_tb;
   localparam time HALF = 32ns;
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
   // each entry: {byte the slave sends, byte the master sends}
   localparam logic [15:0] VEC [6] = '{16'hF1A1, 16'hF2A2, 16'hF3A3,
                                       16'h00FF, 16'hFF00, 16'h5AA5};

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_csn = 1'b1, spi_miso;
   logic late = 1'b1;
   int checks = 0, errors = 0;

   always #2ns clk = ~clk;

   spi_slv_buf u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_csn(spi_csn), .spi_miso(spi_miso)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1ns d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic frame(input logic [7:0] mo, output logic [7:0] mi);
      for (int i = 7; i >= 0; i--) begin
         if (late) begin
            spi_sck = ~spi_sck; spi_mosi = mo[i];
            #HALF mi[i] = spi_miso;
            spi_sck = ~spi_sck;
            #HALF;
         end else begin
            spi_mosi = mo[i];
            #HALF mi[i] = spi_miso;
            spi_sck = ~spi_sck;
            #HALF spi_sck = ~spi_sck;
         end
      end
      #HALF;
   endtask

   task automatic cs_frame(input logic [7:0] mo, output logic [7:0] mi);
      spi_csn = 1'b0;
      #HALF frame(mo, mi);
      spi_csn = 1'b1;
      #HALF;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r, g1, g2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset values
      bus_read(A_CTRL, r); check("R11 ctrl reset", r, 8'h00);
      bus_read(A_STAT, r); check("R11 status reset", r, 8'h02);
      // R1 disabled: write and frame ignored
      bus_write(A_DATA, 8'h77);
      bus_read(A_STAT, r); check("R1 write ignored", r, 8'h02);
      late = 1'b1; spi_sck = 1'b1;
      cs_frame(8'h3C, g1);
      bus_read(A_STAT, r); check("R1 frame ignored", r, 8'h02);

      // enable, idle high, second-edge sampling
      bus_write(A_CTRL, 8'h07);
      bus_read(A_CTRL, r); check("R11 ctrl readback", r, 8'h07);

      // R5 busy rises two clocks after the write
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 8'hE7;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = A_STAT;
      #1ns check("R2 txe cleared", bus_rdata & 8'h82, 8'h00);
      @(negedge clk);
      #1ns check("R5 busy low after 1 edge", bus_rdata & 8'h80, 8'h00);
      @(negedge clk);
      #1ns check("R5 busy high after 2 edges", bus_rdata & 8'h80, 8'h80);
      @(negedge clk); bus_sel = 1'b0;
      cs_frame(8'h18, g1);
      check("R10 mode 1/1 tx byte", g1, 8'hE7);
      bus_read(A_STAT, r); check("R6 busy off, R4 rxf", r, 8'h03);
      bus_read(A_DATA, r); check("R4 rx byte", r, 8'h18);

      // table of full-duplex vectors
      foreach (VEC[k]) begin
         bus_write(A_DATA, VEC[k][15:8]);
         cs_frame(VEC[k][7:0], g1);
         check("R10 master receives", g1, VEC[k][15:8]);
         bus_read(A_STAT, r); check("R4 R6 status after frame", r, 8'h03);
         bus_read(A_DATA, r); check("R4 slave receives", r, VEC[k][7:0]);
         bus_read(A_STAT, r); check("R4 rxf cleared", r, 8'h02);
      end

      // R3 back to back with chip select held low
      bus_write(A_DATA, 8'h5A);
      spi_csn = 1'b0;
      #HALF;
      fork
         begin
            frame(8'h11, g1);
            frame(8'h22, g2);
         end
         begin
            logic [7:0] s;
            s = 8'h00;
            for (int n = 0; n < 400 && !s[1]; n++) bus_read(A_STAT, s);
            check("R6 busy while shifting", s & 8'h80, 8'h80);
            bus_write(A_DATA, 8'hC3);
            s = 8'h00;
            for (int n = 0; n < 400 && !s[0]; n++) bus_read(A_STAT, s);
            bus_read(A_DATA, s);
            check("R4 first of pair", s, 8'h11);
         end
      join
      spi_csn = 1'b1;
      #HALF;
      check("R3 first byte", g1, 8'h5A);
      check("R3 second byte", g2, 8'hC3);
      bus_read(A_DATA, r); check("R3 second rx", r, 8'h22);
      bus_read(A_STAT, r); check("R6 idle after pair", r, 8'h02);

      // R7 R8 transmit-only overrun
      bus_write(A_DATA, 8'h31);
      cs_frame(8'h41, g1);
      bus_write(A_DATA, 8'h32);
      cs_frame(8'h42, g2);
      check("R2 tx-only byte 1", g1, 8'h31);
      check("R2 tx-only byte 2", g2, 8'h32);
      bus_read(A_STAT, r); check("R7 overrun set", r, 8'h43);
      bus_read(A_STAT, r); check("R8 status read alone keeps ovr", r, 8'h43);
      bus_read(A_DATA, r); check("R7 old byte kept", r, 8'h41);
      bus_read(A_STAT, r); check("R8 ovr still shown", r, 8'h42);
      bus_read(A_STAT, r); check("R8 ovr cleared", r, 8'h02);

      // R9 underrun repeats the last byte
      cs_frame(8'h99, g1);
      check("R9 repeat last byte", g1, 8'h32);
      bus_read(A_STAT, r); check("R9 no flag", r, 8'h03);
      bus_read(A_DATA, r); check("R9 rx during underrun", r, 8'h99);

      // R10 idle low, first-edge sampling
      bus_write(A_CTRL, 8'h01);
      late = 1'b0; spi_sck = 1'b0;
      #HALF;
      bus_write(A_DATA, 8'h96);
      cs_frame(8'h69, g1);
      check("R10 mode 0/0 tx", g1, 8'h96);
      bus_read(A_DATA, r); check("R10 mode 0/0 rx", r, 8'h69);
      bus_read(A_STAT, r); check("R6 mode 0/0 idle", r, 8'h02);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule